// File: doc/BRIEF.md
# I2C Master Command Front End

This block sits between a simple register bus and the bit-level engine of an I2C master. Software programs a clock-control register, which carries the block enable and a divider selection, and a control register, which carries the master-select bit, a repeated-start request, and two interrupt flags (byte complete and bus error) with their enables. The block turns each accepted control write into at most one command pulse to the bit engine: start, repeated start, next byte or stop.

When one control write asks for several things, a fixed priority decides: stop beats repeated start, and repeated start beats the next-byte transfer that clearing the byte-complete flag would otherwise trigger. Clearing the enable resets the control and status state, but the bus-error flag and its enable are kept. The block refuses a divider selection that is not allowed and reports the refusal in the status register.

Register map (two address bits, eight data bits, read data is combinational from `reg_addr`): address 0 is control, address 1 is status (read-only), address 2 is clock control, and address 3 reads zero and ignores writes. Control bits: [0] master select, [1] repeated-start request (write-only, reads 0), [2] byte-complete flag, [3] byte-complete interrupt enable, [4] bus-error flag, [5] bus-error interrupt enable. Status bits: [0] master active, [1] divider write refused. Clock-control bits: [1:0] m code, [4:2] n code, [5] extra prescale, [7] enable.

Top module: `i2c_cmd_front`

## Requirements
- R1: A control-register write while the enable bit is 0 changes no control bit and issues no command.
- R2: A control write that moves master select from 0 to 1 issues a start command (code 2'b00). The command pulses `cmd_vld` for one cycle after the write edge, and status bit 0 (active) becomes 1.
- R3: A control write that moves master select from 1 to 0 issues a stop command (code 2'b11). This holds even when the same write clears the byte-complete flag. Status bit 0 returns to 0.
- R4: A control write with bit 1 = 1 that keeps master select at 1 issues a repeated-start command (code 2'b01). This holds even when the same write clears the byte-complete flag.
- R5: A control write that writes 0 to a set byte-complete flag, keeps master select at 1 and has no other request issues a next-byte command (code 2'b10).
- R6: A repeated-start request written while master select is 0 and stays 0 issues no command.
- R7: Writing 0 to a flag bit clears the flag, and writing 1 leaves it unchanged. An `eng_byte_done` or `eng_bus_err` pulse sets the matching flag at the next clock edge.
- R8: `irq` is 1 while a flag and its enable are both 1. It stays 1 until software clears the flag.
- R9: While enable is 0, master select, the byte-complete flag, its enable, and both status bits read 0. The bus-error flag and its enable keep their values.
- R10: A clock-control write with bits [5:0] = 6'b100000 (m code 0, n code 0, extra prescale 1) leaves `clk_div` unchanged and sets status bit 1. The next allowed clock-control write updates `clk_div` and clears status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| eng_byte_done | input | 1 | Bit engine: byte finished pulse |
| eng_bus_err | input | 1 | Bit engine: bus error pulse |
| cmd_vld | output | 1 | One-cycle command strobe to the bit engine |
| cmd_code | output | 2 | Command: 00 start, 01 restart, 10 next byte, 11 stop |
| clk_div | output | 6 | Accepted divider selection for the bit engine |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives writes that combine requests: a stop together with a flag clear, and a restart together with a flag clear. A design with the priority wrong would send a next-byte command where it should end or restart the transfer. A restart written in slave mode must produce no pulse; a design that missed this would drive a restart onto an idle bus. The bench disables the block while a master transfer and the bus-error interrupt are live, so a design that wiped the error bits or kept master select would show it on readback. It also writes the refused divider combination and checks that `clk_div` holds its old value, where a wrong design would take the new one.

// File: rtl/i2c_cmd_front.sv
module i2c_cmd_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       eng_byte_done,
  input  logic       eng_bus_err,
  output logic       cmd_vld,
  output logic [1:0] cmd_code,
  output logic [5:0] clk_div,
  output logic       irq
);
  localparam logic [1:0] CMD_START = 2'b00;
  localparam logic [1:0] CMD_RESTART = 2'b01;
  localparam logic [1:0] CMD_NEXT = 2'b10;
  localparam logic [1:0] CMD_STOP = 2'b11;

  logic en, mst, active, rej;
  logic done_f, done_ie, err_f, err_ie;

  logic ctrl_wr, clk_wr, en_nxt, clk_ok, done_clr;
  logic       nxt_vld;
  logic [1:0] nxt_code;

  assign ctrl_wr  = reg_wr && reg_addr == 2'd0 && en;
  assign clk_wr   = reg_wr && reg_addr == 2'd2;
  assign en_nxt   = clk_wr ? reg_wdata[7] : en;
  assign clk_ok   = reg_wdata[5:0] != 6'b100000;
  assign done_clr = done_f && !reg_wdata[2];

  always_comb begin
    nxt_vld  = 1'b1;
    nxt_code = CMD_NEXT;
    if (!mst && reg_wdata[0])      nxt_code = CMD_START;
    else if (mst && !reg_wdata[0]) nxt_code = CMD_STOP;
    else if (mst && reg_wdata[1])  nxt_code = CMD_RESTART;
    else if (mst && done_clr)      nxt_code = CMD_NEXT;
    else                           nxt_vld  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mst <= 1'b0; active <= 1'b0; rej <= 1'b0;
      done_f <= 1'b0; done_ie <= 1'b0; err_f <= 1'b0; err_ie <= 1'b0;
      clk_div <= '0; cmd_vld <= 1'b0; cmd_code <= CMD_START;
    end else begin
      cmd_vld <= ctrl_wr && nxt_vld;
      if (ctrl_wr && nxt_vld) cmd_code <= nxt_code;
      en <= en_nxt;
      if (clk_wr && clk_ok) clk_div <= reg_wdata[5:0];
      if (!en_nxt) begin
        mst <= 1'b0; active <= 1'b0; rej <= 1'b0;
        done_f <= 1'b0; done_ie <= 1'b0;
      end else begin
        if (clk_wr) rej <= !clk_ok;
        if (ctrl_wr) begin
          mst     <= reg_wdata[0];
          done_ie <= reg_wdata[3];
          err_ie  <= reg_wdata[5];
          if (!reg_wdata[2]) done_f <= 1'b0;
          if (!reg_wdata[4]) err_f  <= 1'b0;
          if (nxt_vld && nxt_code == CMD_START) active <= 1'b1;
          if (nxt_vld && nxt_code == CMD_STOP)  active <= 1'b0;
        end
        if (eng_byte_done) done_f <= 1'b1;
      end
      if (eng_bus_err) err_f <= 1'b1;
    end
  end

  assign irq = (done_f && done_ie) || (err_f && err_ie);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {2'b00, err_ie, err_f, done_ie, done_f, 1'b0, mst};
      2'd1:    reg_rdata = {6'b0, rej, active};
      2'd2:    reg_rdata = {en, 1'b0, clk_div};
      default: reg_rdata = 8'h00;
    endcase
  end

  // R1
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !en) |=> (!cmd_vld && $stable(mst) && $stable(err_ie)));

  // R3
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && en && mst && !reg_wdata[0]) |=> (cmd_vld && cmd_code == CMD_STOP));

  // R6
  slave_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !mst && !reg_wdata[0]) |=> !cmd_vld);

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_byte_done && en && !(reg_wr && reg_addr == 2'd2)) |=> done_f);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);

  // R9
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!mst && !done_f && !done_ie && !active && !rej));

  // R10
  clk_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[5:0] == 6'b100000) |=> $stable(clk_div));
endmodule

// File: tb/i2c_cmd_front_bench.sv
module i2c_cmd_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic eng_byte_done = 1'b0;
  logic eng_bus_err = 1'b0;
  logic cmd_vld;
  logic [1:0] cmd_code;
  logic [5:0] clk_div;
  logic irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_cmd_front u_i2c_cmd_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_byte_done(eng_byte_done), .eng_bus_err(eng_bus_err),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .clk_div(clk_div), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  // after wr returns, the command strobe of that write is visible
  task automatic expect_cmd(input int code, input string tag);
    check({tag, " vld"}, cmd_vld, 1);
    check({tag, " code"}, cmd_code, code);
  endtask

  task automatic pulse_done;
    @(negedge clk); eng_byte_done = 1'b1;
    @(negedge clk); eng_byte_done = 1'b0;
  endtask

  task automatic pulse_err;
    @(negedge clk); eng_bus_err = 1'b1;
    @(negedge clk); eng_bus_err = 1'b0;
  endtask

  task automatic t_reset;
    rd(2'd0, 0, "reset ctrl");
    rd(2'd1, 0, "reset stat");
    rd(2'd2, 0, "reset clk");
    check("reset irq", irq, 0);
  endtask

  task automatic t_locked;
    wr(2'd0, 8'h29);
    check("R1 no cmd", cmd_vld, 0);
    rd(2'd0, 0, "R1 ctrl unchanged");
  endtask

  task automatic t_clock;
    wr(2'd2, 8'h85);
    check("R10 legal div", clk_div, 5);
    rd(2'd1, 0, "R10 no reject");
    wr(2'd2, 8'hA0);
    check("R10 refused div kept", clk_div, 5);
    rd(2'd1, 2, "R10 reject flag");
    wr(2'd2, 8'h81);
    check("R10 next legal div", clk_div, 1);
    rd(2'd1, 0, "R10 reject cleared");
  endtask

  task automatic t_start_next;
    wr(2'd0, 8'h01);
    expect_cmd(0, "R2 start");
    rd(2'd1, 1, "R2 active");
    pulse_done();
    rd(2'd0, 8'h05, "R7 done set");
    wr(2'd0, 8'h0D);
    check("R7 write1 no cmd", cmd_vld, 0);
    rd(2'd0, 8'h0D, "R7 write1 keeps flag");
    check("R8 irq on", irq, 1);
    @(negedge clk);
    check("R8 irq held", irq, 1);
    wr(2'd0, 8'h09);
    expect_cmd(2, "R5 next");
    check("R8 irq off", irq, 0);
    @(negedge clk);
    check("R2 pulse one cycle", cmd_vld, 0);
  endtask

  task automatic t_restart;
    pulse_done();
    wr(2'd0, 8'h0B);
    expect_cmd(1, "R4 restart wins");
    rd(2'd0, 8'h09, "R4 flag cleared");
  endtask

  task automatic t_stop;
    pulse_done();
    wr(2'd0, 8'h0A);
    expect_cmd(3, "R3 stop wins");
    rd(2'd1, 0, "R3 inactive");
  endtask

  task automatic t_slave_rs;
    wr(2'd0, 8'h02);
    check("R6 no cmd", cmd_vld, 0);
    rd(2'd0, 0, "R6 ctrl");
  endtask

  task automatic t_disable;
    pulse_err();
    rd(2'd0, 8'h10, "R7 err set");
    wr(2'd0, 8'h3D);
    expect_cmd(0, "R2 start again");
    check("R8 err irq", irq, 1);
    wr(2'd2, 8'h01);
    rd(2'd0, 8'h30, "R9 ctrl after disable");
    rd(2'd1, 0, "R9 stat after disable");
    check("R9 irq kept", irq, 1);
    wr(2'd2, 8'h81);
    wr(2'd0, 8'h20);
    rd(2'd0, 8'h20, "R7 err cleared");
    check("R7 irq cleared", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_clock();
        t_start_next();
        t_restart();
        t_stop();
        t_slave_rs();
        t_disable();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule